// File: doc/BRIEF.md
# Chunk Loader for Microcontroller Local Memories

This block is the boot-time copy engine that sits beside a small embedded controller. It copies one fixed 256-byte chunk at a time from an external memory into either the controller's instruction store or its data store. Software drives it through a 32-bit register bus. It first writes a chunk-aligned external base, an external byte offset and a local-memory offset. It then writes the command register, and that write launches the copy. Software polls the idle flag in the same command register before it issues the next chunk.

The engine issues 64 word reads on a valid/ready read port, one request at a time, walking upward from the external start address. Each returned word is written one cycle later into the selected local array. The local offset is forced down to a chunk boundary. The base, both offsets and the destination are captured when the transfer starts, so software may reprogram them while a chunk is still moving.

Top module: `lmem_chunk_loader`

## Requirements
- R1: After reset the base, local-offset, external-offset and control registers read 0, the command register reads 0x0000_0002 (idle set, destination and size fields 0), no read request is raised and neither local write enable is set.
- R2: The registers decode at these 16-bit offsets: control 0x110C, base 0x1110, local offset 0x1114, command 0x1118, external offset 0x111C. Base and both offsets read back the full 32-bit value written. Control reads back the written value with bits 2:1 (the scrub-in-progress flags) as 0. Any other offset reads 0.
- R3: A command write while idle starts a transfer. From the next cycle the command register's bit 1 (idle) reads 0, and the first read request is raised in that same cycle.
- R4: A transfer makes exactly 64 word reads, in order, at external addresses (base << 8) + external offset + 4·k for k = 0..63, computed modulo 2^32.
- R5: A raised read request keeps its address unchanged until ready is seen; each cycle with both valid and ready moves one word.
- R6: The word taken in a handshake cycle is written, in the following cycle, to local word address (local offset / 4 rounded down to a multiple of 64) + k, modulo the array's word count, with the data unchanged.
- R7: Command bit 4 set sends every word of the chunk to the instruction array; bit 4 clear sends every word to the data array. The other array's write enable stays low throughout.
- R8: The idle bit reads 1 again in the cycle right after the cycle in which the last word is written.
- R9: A command write while busy is ignored. It starts no further reads. The running chunk keeps its destination. After the chunk ends, the command register still shows the destination (bit 4) and size code (bits 10:8) of the accepted command.
- R10: The size code in command bits 10:8 is stored for readback. Any value, including values other than 6, moves a 256-byte chunk of 64 words.
- R11: A local offset that is not a multiple of 256 behaves exactly like the same offset with its low 8 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 16 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ext_rd_valid | output | 1 | External word read request |
| ext_rd_addr | output | 32 | External byte address of the requested word |
| ext_rd_ready | input | 1 | External memory accepts the request and returns data this cycle |
| ext_rd_data | input | 32 | External read data, valid while valid and ready are high |
| imem_we | output | 1 | Instruction array write enable |
| imem_addr | output | 10 | Instruction array word address |
| imem_wdata | output | 32 | Instruction array write data |
| dmem_we | output | 1 | Data array write enable |
| dmem_addr | output | 10 | Data array word address |
| dmem_wdata | output | 32 | Data array write data |

## Verification
Register reads are combinational and are due in the cycle the offset is presented. A command write sampled at one edge makes the idle bit read 0 and raises the first request in the very next cycle. Each handshake produces its local write one cycle later, and idle returns one cycle after the last write. The bench drives inputs 2 ns after each rising edge and samples at the falling edge, stamping every handshake, write and idle poll with a cycle index. It polls idle on every consecutive cycle, so each of these latencies is compared as an exact cycle difference and not merely an eventual outcome.

// File: rtl/lcl_pkg.sv
package lcl_pkg;

  localparam logic [15:0] OFS_CTRL = 16'h110C;
  localparam logic [15:0] OFS_BASE = 16'h1110;
  localparam logic [15:0] OFS_LOFF = 16'h1114;
  localparam logic [15:0] OFS_CMD  = 16'h1118;
  localparam logic [15:0] OFS_EOFF = 16'h111C;

  localparam int CMD_IDLE_BIT = 1;
  localparam int CMD_TGT_BIT  = 4;
  localparam int CMD_SZ_LSB   = 8;
  localparam int CMD_SZ_W     = 3;

  localparam logic [31:0] CTRL_SCRUB_MASK = 32'h0000_0006;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  // External byte address of word idx of a chunk.
  function automatic logic [31:0] ext_word_addr(input logic [31:0] base,
                                                input logic [31:0] eoff,
                                                input logic [31:0] idx,
                                                input int          shift);
    return (base << shift) + eoff + (idx << 2);
  endfunction

  // Local word address of word idx; the offset drops to a chunk boundary.
  function automatic logic [31:0] chunk_word(input logic [31:0] loff,
                                             input logic [31:0] idx,
                                             input int          words);
    logic [31:0] keep;
    keep = ~(32'(words) - 32'd1);
    return ((loff >> 2) & keep) + idx;
  endfunction

endpackage

// File: rtl/lcl_regs.sv
module lcl_regs
  import lcl_pkg::*;
#(
  parameter int REG_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  output logic [31:0]       reg_rdata,
  output logic              start_pulse,
  output logic [31:0]       base_q,
  output logic [31:0]       loff_q,
  output logic [31:0]       eoff_q,
  output logic              tgt_imem_q
);

  logic [31:0]         ctrl_q;
  logic [CMD_SZ_W-1:0] size_q;
  logic                hit_ctrl, hit_base, hit_loff, hit_cmd, hit_eoff;

  assign hit_ctrl = (reg_addr == REG_AW'(OFS_CTRL));
  assign hit_base = (reg_addr == REG_AW'(OFS_BASE));
  assign hit_loff = (reg_addr == REG_AW'(OFS_LOFF));
  assign hit_cmd  = (reg_addr == REG_AW'(OFS_CMD));
  assign hit_eoff = (reg_addr == REG_AW'(OFS_EOFF));

  assign start_pulse = reg_wr && hit_cmd && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      base_q     <= '0;
      loff_q     <= '0;
      eoff_q     <= '0;
      tgt_imem_q <= 1'b0;
      size_q     <= '0;
    end else begin
      if (reg_wr && hit_ctrl) ctrl_q <= reg_wdata & ~CTRL_SCRUB_MASK;
      if (reg_wr && hit_base) base_q <= reg_wdata;
      if (reg_wr && hit_loff) loff_q <= reg_wdata;
      if (reg_wr && hit_eoff) eoff_q <= reg_wdata;
      if (start_pulse) begin
        tgt_imem_q <= reg_wdata[CMD_TGT_BIT];
        size_q     <= reg_wdata[CMD_SZ_LSB +: CMD_SZ_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) reg_rdata = ctrl_q;
    if (hit_base) reg_rdata = base_q;
    if (hit_loff) reg_rdata = loff_q;
    if (hit_eoff) reg_rdata = eoff_q;
    if (hit_cmd) begin
      reg_rdata[CMD_IDLE_BIT]               = !busy;
      reg_rdata[CMD_TGT_BIT]                = tgt_imem_q;
      reg_rdata[CMD_SZ_LSB +: CMD_SZ_W]     = size_q;
    end
  end

endmodule

// File: rtl/lcl_xfer_seq.sv
module lcl_xfer_seq
  import lcl_pkg::*;
#(
  parameter int WORDS      = 64,
  parameter int BASE_SHIFT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_pulse,
  input  logic [31:0] base_in,
  input  logic [31:0] eoff_in,
  input  logic [31:0] loff_in,
  input  logic        tgt_in,
  input  logic        ext_rd_ready,
  input  logic        wr_last,
  output logic        ext_rd_valid,
  output logic [31:0] ext_rd_addr,
  output logic        busy,
  output logic        beat_fire,
  output logic        beat_last,
  output logic        beat_tgt,
  output logic [31:0] beat_lword
);

  localparam int CW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(WORDS - 1);

  seq_state_e  state_q;
  logic [CW-1:0] cnt_q;
  logic [31:0] base_c, eoff_c, loff_c;
  logic        tgt_c;

  assign busy         = (state_q != SEQ_IDLE);
  assign ext_rd_valid = (state_q == SEQ_FETCH);
  assign beat_fire    = ext_rd_valid && ext_rd_ready;
  assign beat_last    = beat_fire && (cnt_q == LAST_IDX);
  assign beat_tgt     = tgt_c;
  assign ext_rd_addr  = ext_word_addr(base_c, eoff_c, 32'(cnt_q), BASE_SHIFT);
  assign beat_lword   = chunk_word(loff_c, 32'(cnt_q), WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      base_c  <= '0;
      eoff_c  <= '0;
      loff_c  <= '0;
      tgt_c   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_pulse) begin
            base_c  <= base_in;
            eoff_c  <= eoff_in;
            loff_c  <= loff_in;
            tgt_c   <= tgt_in;
            cnt_q   <= '0;
            state_q <= SEQ_FETCH;
          end
        end
        SEQ_FETCH: begin
          if (beat_fire) begin
            cnt_q <= cnt_q + 1'b1;
            if (beat_last) state_q <= SEQ_DRAIN;
          end
        end
        SEQ_DRAIN: begin
          if (wr_last) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcl_wr_steer.sv
module lcl_wr_steer #(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_fire,
  input  logic               beat_last,
  input  logic               beat_tgt,
  input  logic [31:0]        beat_lword,
  input  logic [31:0]        beat_data,
  output logic               wr_last,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata,
  output logic               dmem_we,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic [31:0]        dmem_wdata
);

  logic        wv_q, wl_q, wt_q;
  logic [31:0] wa_q, wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv_q <= 1'b0;
      wl_q <= 1'b0;
      wt_q <= 1'b0;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wv_q <= beat_fire;
      wl_q <= beat_last;
      if (beat_fire) begin
        wt_q <= beat_tgt;
        wa_q <= beat_lword;
        wd_q <= beat_data;
      end
    end
  end

  assign wr_last    = wv_q && wl_q;
  assign imem_we    = wv_q && wt_q;
  assign dmem_we    = wv_q && !wt_q;
  assign imem_addr  = IMEM_AW'(wa_q);
  assign dmem_addr  = DMEM_AW'(wa_q);
  assign imem_wdata = wd_q;
  assign dmem_wdata = wd_q;

endmodule

// File: rtl/lmem_chunk_loader.sv
module lmem_chunk_loader #(
  parameter int CHUNK_BYTES = 256,
  parameter int IMEM_WORDS  = 1024,
  parameter int DMEM_WORDS  = 1024,
  parameter int REG_AW      = 16,
  localparam int WORDS      = CHUNK_BYTES / 4,
  localparam int BASE_SHIFT = $clog2(CHUNK_BYTES),
  localparam int IMEM_AW    = $clog2(IMEM_WORDS),
  localparam int DMEM_AW    = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               ext_rd_valid,
  output logic [31:0]        ext_rd_addr,
  input  logic               ext_rd_ready,
  input  logic [31:0]        ext_rd_data,
  output logic               imem_we,
  output logic [IMEM_AW-1:0] imem_addr,
  output logic [31:0]        imem_wdata,
  output logic               dmem_we,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic [31:0]        dmem_wdata
);

  logic        busy;
  logic        start_pulse;
  logic        beat_fire;
  logic        beat_last;
  logic        beat_tgt;
  logic        wr_last;
  logic [31:0] beat_lword;
  logic [31:0] base_q, loff_q, eoff_q;
  logic        tgt_imem_q;

  lcl_regs #(.REG_AW(REG_AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .busy        (busy),
    .reg_rdata   (reg_rdata),
    .start_pulse (start_pulse),
    .base_q      (base_q),
    .loff_q      (loff_q),
    .eoff_q      (eoff_q),
    .tgt_imem_q  (tgt_imem_q)
  );

  lcl_xfer_seq #(.WORDS(WORDS), .BASE_SHIFT(BASE_SHIFT)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_pulse  (start_pulse),
    .base_in      (base_q),
    .eoff_in      (eoff_q),
    .loff_in      (loff_q),
    .tgt_in       (reg_wdata[lcl_pkg::CMD_TGT_BIT]),
    .ext_rd_ready (ext_rd_ready),
    .wr_last      (wr_last),
    .ext_rd_valid (ext_rd_valid),
    .ext_rd_addr  (ext_rd_addr),
    .busy         (busy),
    .beat_fire    (beat_fire),
    .beat_last    (beat_last),
    .beat_tgt     (beat_tgt),
    .beat_lword   (beat_lword)
  );

  lcl_wr_steer #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_fire  (beat_fire),
    .beat_last  (beat_last),
    .beat_tgt   (beat_tgt),
    .beat_lword (beat_lword),
    .beat_data  (ext_rd_data),
    .wr_last    (wr_last),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .imem_wdata (imem_wdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata)
  );

  // The destination latched in u_regs only feeds readback; the sequencer
  // takes its own copy from the accepted command word.
  logic unused_tgt;
  assign unused_tgt = tgt_imem_q;

endmodule

// File: rtl/lcl_loader_chk.sv
module lcl_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_rd_valid,
  input logic        ext_rd_ready,
  input logic [31:0] ext_rd_addr,
  input logic        imem_we,
  input logic        dmem_we,
  input logic        busy,
  input logic        start_pulse,
  input logic        beat_fire,
  input logic        beat_last,
  input logic        wr_last
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(imem_we && dmem_we)); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> busy); // R3

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ext_rd_valid); // R3

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_valid && !ext_rd_ready) |=> (ext_rd_valid && $stable(ext_rd_addr))); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !beat_last) |=> (ext_rd_addr == $past(ext_rd_addr) + 32'd4)); // R4

  AST_BEAT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> (imem_we || dmem_we)); // R6

  AST_WRITE_HAS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_we || dmem_we) |-> $past(beat_fire)); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> !busy); // R8

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_pulse); // R9

endmodule

bind lmem_chunk_loader lcl_loader_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ext_rd_valid (ext_rd_valid),
  .ext_rd_ready (ext_rd_ready),
  .ext_rd_addr  (ext_rd_addr),
  .imem_we      (imem_we),
  .dmem_we      (dmem_we),
  .busy         (busy),
  .start_pulse  (start_pulse),
  .beat_fire    (beat_fire),
  .beat_last    (beat_last),
  .wr_last      (wr_last)
);

// File: tb/test_lmem_chunk_loader.sv
`timescale 1ns/1ps
module test_lmem_chunk_loader;

  localparam int MEMW = 1024;
  localparam logic [15:0] A_CTRL = 16'h110C, A_BASE = 16'h1110,
                          A_LOFF = 16'h1114, A_CMD  = 16'h1118,
                          A_EOFF = 16'h111C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_rd_valid;
  logic [31:0] ext_rd_addr;
  logic        ext_rd_ready = 1'b1;
  logic [31:0] ext_rd_data;
  logic        imem_we, dmem_we;
  logic [9:0]  imem_addr, dmem_addr;
  logic [31:0] imem_wdata, dmem_wdata;

  lmem_chunk_loader i_lmem_chunk_loader (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_rd_valid(ext_rd_valid), .ext_rd_addr(ext_rd_addr),
    .ext_rd_ready(ext_rd_ready), .ext_rd_data(ext_rd_data),
    .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] ext_model(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16]};
  endfunction
  assign ext_rd_data = ext_model(ext_rd_addr);

  int vectors = 0, miscompares = 0, cyc = 0;
  bit stall_mode = 1'b0, done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    @(posedge clk); #2;
    ext_rd_ready = stall_mode ? ((cyc % 3) == 2) : 1'b1;
  end

  logic [31:0] hs_a[128], wr_a[128], wr_d[128];
  int          hs_c[128], wr_c[128];
  bit          wr_i[128];
  int          hs_n = 0, wr_n = 0, hold_viol = 0, both_viol = 0;
  logic        pv = 1'b0;
  logic [31:0] pa = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !(ext_rd_valid && ext_rd_addr == pa)) hold_viol++;
      pv = ext_rd_valid && !ext_rd_ready;
      pa = ext_rd_addr;
      if (ext_rd_valid && ext_rd_ready && hs_n < 128) begin
        hs_a[hs_n] = ext_rd_addr; hs_c[hs_n] = cyc; hs_n++;
      end
      if (imem_we && dmem_we) both_viol++;
      if (imem_we && wr_n < 128) begin
        wr_a[wr_n] = 32'(imem_addr); wr_d[wr_n] = imem_wdata;
        wr_i[wr_n] = 1'b1; wr_c[wr_n] = cyc; wr_n++;
      end else if (dmem_we && wr_n < 128) begin
        wr_a[wr_n] = 32'(dmem_addr); wr_d[wr_n] = dmem_wdata;
        wr_i[wr_n] = 1'b0; wr_c[wr_n] = cyc; wr_n++;
      end
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [31:0] d, output int c);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata; c = cyc;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One chunk; interfere=1 issues a second command mid-transfer.
  task automatic run_chunk(input logic [31:0] base, input logic [31:0] eoff,
                           input logic [31:0] loff, input logic [31:0] cmd,
                           input bit stall, input bit interfere);
    logic [31:0] v, ebase, lbase;
    int c, idle_c, bad, k;
    bit tgt, seen;
    tgt = cmd[4];
    stall_mode = stall;
    wr_reg(A_BASE, base);
    wr_reg(A_EOFF, eoff);
    wr_reg(A_LOFF, loff);
    hs_n = 0; wr_n = 0; hold_viol = 0; both_viol = 0;
    wr_reg(A_CMD, cmd);
    rd_reg(A_CMD, v, c);
    check(v[1] == 1'b0, "R3 idle clears next cycle", v, 32'h0);
    check(hs_n == 0 && ext_rd_valid, "R3 first request next cycle",
          32'(ext_rd_valid), 32'h1);
    if (interfere) begin
      repeat (5) @(posedge clk);
      wr_reg(A_CMD, {cmd[31:5], ~cmd[4], cmd[3:0]} ^ 32'h0000_0500);
    end
    seen = 1'b0; idle_c = 0;
    for (int n = 0; n < 2000 && !seen; n++) begin
      @(posedge clk); #2;
      rd_reg(A_CMD, v, c);
      if (v[1]) begin seen = 1'b1; idle_c = c; end
    end
    check(seen, "R8 transfer finished", 32'(seen), 32'h1);
    check(hs_n == 64, "R4/R10 beat count", hs_n, 64);
    ebase = (base << 8) + eoff;
    bad = -1;
    for (k = 0; k < hs_n && k < 64; k++)
      if (bad < 0 && hs_a[k] != ebase + 32'(k) * 4) bad = k;
    check(bad < 0, "R4 external address", (bad < 0) ? 32'h0 : hs_a[bad],
          (bad < 0) ? 32'h0 : ebase + 32'(bad) * 4);
    check(wr_n == 64, "R6 write count", wr_n, 64);
    lbase = (loff >> 2) & ~32'd63;
    bad = -1;
    for (k = 0; k < wr_n && k < 64; k++)
      if (bad < 0 && wr_a[k] != ((lbase + 32'(k)) & (MEMW - 1))) bad = k;
    check(bad < 0, "R6/R11 local address", (bad < 0) ? 32'h0 : wr_a[bad],
          (bad < 0) ? 32'h0 : ((lbase + 32'(bad)) & (MEMW - 1)));
    bad = -1;
    for (k = 0; k < wr_n && k < 64; k++)
      if (bad < 0 && wr_d[k] != ext_model(ebase + 32'(k) * 4)) bad = k;
    check(bad < 0, "R6 write data", (bad < 0) ? 32'h0 : wr_d[bad],
          (bad < 0) ? 32'h0 : ext_model(ebase + 32'(bad) * 4));
    bad = -1;
    for (k = 0; k < wr_n && k < 64 && k < hs_n; k++)
      if (bad < 0 && wr_c[k] != hs_c[k] + 1) bad = k;
    check(bad < 0, "R6 write one cycle after handshake",
          (bad < 0) ? 32'h0 : 32'(wr_c[bad]), (bad < 0) ? 32'h0 : 32'(hs_c[bad] + 1));
    bad = -1;
    for (k = 0; k < wr_n && k < 64; k++)
      if (bad < 0 && wr_i[k] != tgt) bad = k;
    check(bad < 0 && both_viol == 0, "R7 destination array",
          (bad < 0) ? 32'(tgt) : 32'(wr_i[bad]), 32'(tgt));
    if (wr_n > 0)
      check(idle_c == wr_c[wr_n - 1] + 1, "R8 idle timing", idle_c, wr_c[wr_n - 1] + 1);
    if (stall) check(hold_viol == 0, "R5 request held until ready", hold_viol, 0);
    rd_reg(A_CMD, v, c);
    check(v == ((cmd & 32'h0000_0710) | 32'h2), interfere ? "R9 command readback" :
          "R10 command readback", v, (cmd & 32'h0000_0710) | 32'h2);
    repeat (8) @(posedge clk);
    check(hs_n == 64 && wr_n == 64, interfere ? "R9 no extra transfer" :
          "R3 quiet after chunk", 32'(hs_n + wr_n), 32'd128);
    stall_mode = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v; int c;
    rd_reg(A_CMD, v, c);  check(v == 32'h2, "R1 command reset", v, 32'h2);
    rd_reg(A_BASE, v, c); check(v == 32'h0, "R1 base reset", v, 32'h0);
    rd_reg(A_LOFF, v, c); check(v == 32'h0, "R1 local offset reset", v, 32'h0);
    rd_reg(A_EOFF, v, c); check(v == 32'h0, "R1 external offset reset", v, 32'h0);
    rd_reg(A_CTRL, v, c); check(v == 32'h0, "R1 control reset", v, 32'h0);
    check(!ext_rd_valid && !imem_we && !dmem_we, "R1 outputs quiet",
          {29'b0, ext_rd_valid, imem_we, dmem_we}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v; int c;
    wr_reg(A_BASE, 32'hDEAD_BEEF); rd_reg(A_BASE, v, c);
    check(v == 32'hDEAD_BEEF, "R2 base readback", v, 32'hDEAD_BEEF);
    wr_reg(A_LOFF, 32'h1234_5678); rd_reg(A_LOFF, v, c);
    check(v == 32'h1234_5678, "R2 local offset readback", v, 32'h1234_5678);
    wr_reg(A_EOFF, 32'hCAFE_F00D); rd_reg(A_EOFF, v, c);
    check(v == 32'hCAFE_F00D, "R2 external offset readback", v, 32'hCAFE_F00D);
    wr_reg(A_CTRL, 32'hFFFF_FFFF); rd_reg(A_CTRL, v, c);
    check(v == 32'hFFFF_FFF9, "R2 control scrub bits zero", v, 32'hFFFF_FFF9);
    wr_reg(A_CTRL, 32'h0); rd_reg(A_CTRL, v, c);
    check(v == 32'h0, "R2 control cleared", v, 32'h0);
    rd_reg(16'h1100, v, c);
    check(v == 32'h0, "R2 unmapped offset", v, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "WATCHDOG expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    t_reset();
    t_regs();
    run_chunk(32'h0000_0123, 32'h0000_0040, 32'h0000_0100, 32'h0000_0600, 1'b0, 1'b0);
    run_chunk(32'h0000_4567, 32'h0000_0000, 32'h0000_0800, 32'h0000_0610, 1'b1, 1'b0);
    run_chunk(32'h0000_0200, 32'h0000_0010, 32'h0000_0200, 32'h0000_0600, 1'b0, 1'b1);
    run_chunk(32'h0000_0300, 32'h0000_0100, 32'h0000_0000, 32'h0000_0310, 1'b0, 1'b0);
    run_chunk(32'h0000_0300, 32'h0000_0100, 32'h1234_0388, 32'h0000_0000, 1'b1, 1'b0);
    run_chunk(32'h00FF_FFFF, 32'h0000_00F0, 32'h0000_0FC0, 32'h0000_0710, 1'b0, 1'b0);
    finish_run();
  end

endmodule